// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps processor byte addresses in the low RAM window onto physical pages. It looks up a 1024-entry, 16-bit page table that the block holds itself. A translation request carries a 24-bit address, a direction flag and a strobe. The page table entry is selected by address bits 21:12, and its low ten bits replace those address bits, while the 4 KB page offset is kept as it is. Any address at or above 0x400000 is outside the window and leaves the block unchanged. The result is registered and appears one cycle after the strobe, together with a one-cycle valid pulse.

Each translation also updates the entry it used, in the same cycle, as a read-modify-write. The update only happens when the entry's two-bit status field is non-zero, which means the page is present. A read sets the referenced flag. A write sets both the referenced flag and the modified flag. The write-protect-enable flag in the top bit and every other bit are carried through untouched.

Software loads and inspects entries through a host port that takes byte or word accesses. The table appears as 2 KB of big-endian storage, repeated across a 64 KB host address range.

Top module: `paged_xlate_unit`

## Requirements
- R1: An address with any of bits 23:22 set leaves the block unchanged on `out_addr`, and no table entry is modified by that request.
- R2: For an address below 0x400000, `out_addr` is bits 23:22 zero, then entry bits 9:0 as the physical page, then address bits 11:0. The entry used is the one indexed by address bits 21:12.
- R3: `out_valid` is high for exactly the one cycle after each cycle in which `xl_req` is high, and is low otherwise. After reset, `out_valid`, `out_addr` and `host_rdata` are all zero.
- R4: An entry whose status field (bits 14:13) is 00 is left exactly as it was by any translation.
- R5: A read translation (`xl_write` = 0) of a present page sets entry bit 14 and changes no other bit.
- R6: A write translation (`xl_write` = 1) of a present page sets entry bits 14 and 13. Bit 15 and bits 12:0 keep their values.
- R7: A host word access uses `host_addr` bits 10:1 as the entry index and ignores bit 0. A word write stores `host_wdata` whole. A word read returns the entry on `host_rdata` in the cycle after the request.
- R8: A host byte access with `host_addr` bit 0 = 0 addresses entry bits 15:8, and with bit 0 = 1 it addresses bits 7:0. A byte write stores `host_wdata[7:0]` into that byte only. A byte read returns the byte in `host_rdata[7:0]`, with bits 15:8 zero, one cycle later.
- R9: `host_addr` bits 15:11 have no effect: every 2 KB block of the host range reaches the same table.
- R10: When a host write (word or byte) and a status update target the same entry in the same cycle, only the host write takes effect. The translation still uses the entry value from before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xl_req | input | 1 | Translation strobe |
| xl_write | input | 1 | Direction of the translated access: 1 = write |
| xl_addr | input | 24 | Processor byte address |
| out_valid | output | 1 | One-cycle pulse that qualifies `out_addr` |
| out_addr | output | 24 | Translated or passed-through address |
| host_req | input | 1 | Host access strobe |
| host_wr | input | 1 | Host access direction: 1 = write |
| host_byte | input | 1 | Host access size: 1 = byte, 0 = word |
| host_addr | input | 16 | Host byte address inside the mirrored range |
| host_wdata | input | 16 | Host write data (byte writes use bits 7:0) |
| host_rdata | output | 16 | Host read data, one cycle after a read request |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 4 KB pages, a 1024-entry table and a 16-bit host range. With these values the top page below 0x400000 and the first address above it can both be reached directly, so the window boundary is tested on the real edge. The full 16-bit host address lets random accesses land in every mirror of the 2 KB table. Random page indices are steered onto the host index often enough to produce many same-entry collisions between host writes and status updates. Random entry contents leave about a quarter of the pages not present.

// File: rtl/atu_pkg.sv
`timescale 1ns/1ps
package atu_pkg;
  localparam int ENT_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int ENT_BYTES = ENT_W / BYTE_W;
  // bit positions inside a table entry (software and the status update agree on these)
  localparam int WPROT_BIT = 15;
  localparam int REF_BIT   = 14;
  localparam int MOD_BIT   = 13;

  typedef logic [ENT_W-1:0] map_entry_t;

  typedef enum logic [1:0] {
    HOP_IDLE,
    HOP_READ,
    HOP_WR_WORD,
    HOP_WR_BYTE
  } host_op_e;

  function automatic logic page_present(input map_entry_t e);
    return e[REF_BIT] | e[MOD_BIT];
  endfunction
endpackage

// File: rtl/atu_rst_sync.sv
`timescale 1ns/1ps
module atu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/atu_map_mem.sv
`timescale 1ns/1ps
module atu_map_mem
  import atu_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                 clk,
  // port A: translation lookup and status write-back
  input  logic [IDX_W-1:0]     a_idx,
  output map_entry_t           a_rdata,
  input  logic                 a_we,
  input  map_entry_t           a_wdata,
  // port B: host access with byte lanes
  input  logic [IDX_W-1:0]     b_idx,
  output map_entry_t           b_rdata,
  input  logic                 b_we,
  input  logic [ENT_BYTES-1:0] b_be,
  input  map_entry_t           b_wdata
);
  localparam int DEPTH = 1 << IDX_W;

  map_entry_t table_q [DEPTH];

  assign a_rdata = table_q[a_idx];
  assign b_rdata = table_q[b_idx];

  // Host lanes are written after the status word, so the host wins on a shared index;
  // the owning logic also suppresses a_we in that case.
  always_ff @(posedge clk) begin
    if (a_we) table_q[a_idx] <= a_wdata;
    if (b_we) begin
      for (int ln = 0; ln < ENT_BYTES; ln++) begin
        if (b_be[ln]) table_q[b_idx][ln*BYTE_W +: BYTE_W] <= b_wdata[ln*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/atu_host_port.sv
`timescale 1ns/1ps
module atu_host_port
  import atu_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int HOST_AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_wr,
  input  logic                 host_byte,
  input  logic [HOST_AW-1:0]   host_addr,
  input  map_entry_t           host_wdata,
  input  map_entry_t           rd_entry,
  output logic [IDX_W-1:0]     idx,
  output logic                 wr_en,
  output logic [ENT_BYTES-1:0] wr_be,
  output map_entry_t           wr_data,
  output map_entry_t           host_rdata
);
  host_op_e   op;
  logic       sel_lane;
  logic [BYTE_W-1:0] rd_byte;
  map_entry_t rdata_d;
  map_entry_t rdata_q;
  logic       rd_en;
  logic       mirror_unused;

  always_comb begin
    if (!host_req)      op = HOP_IDLE;
    else if (!host_wr)  op = HOP_READ;
    else if (host_byte) op = HOP_WR_BYTE;
    else                op = HOP_WR_WORD;
  end

  // big-endian: even byte address is the upper lane
  assign sel_lane      = ~host_addr[0];
  assign idx           = host_addr[IDX_W:1];
  assign mirror_unused = ^host_addr[HOST_AW-1:IDX_W+1];
  assign wr_en         = (op == HOP_WR_WORD) || (op == HOP_WR_BYTE);
  assign rd_en         = (op == HOP_READ);

  for (genvar g = 0; g < ENT_BYTES; g++) begin : g_lane
    assign wr_be[g] = (op == HOP_WR_WORD) || ((op == HOP_WR_BYTE) && (sel_lane == 1'(g)));
    assign wr_data[g*BYTE_W +: BYTE_W] =
      (op == HOP_WR_BYTE) ? host_wdata[BYTE_W-1:0] : host_wdata[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rd_byte = sel_lane ? rd_entry[ENT_W-1 -: BYTE_W] : rd_entry[BYTE_W-1:0];
    rdata_d = host_byte ? map_entry_t'({{(ENT_W-BYTE_W){1'b0}}, rd_byte}) : rd_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/atu_status_upd.sv
`timescale 1ns/1ps
module atu_status_upd
  import atu_pkg::*;
(
  input  logic       xl_req,
  input  logic       xl_write,
  input  logic       in_window,
  input  logic       host_hit,
  input  map_entry_t cur_entry,
  output logic       upd_we,
  output map_entry_t upd_entry
);
  always_comb begin
    upd_entry          = cur_entry;
    upd_entry[REF_BIT] = 1'b1;
    if (xl_write) upd_entry[MOD_BIT] = 1'b1;
    upd_we = xl_req && in_window && page_present(cur_entry) && !host_hit;
  end
endmodule

// File: rtl/paged_xlate_unit.sv
`timescale 1ns/1ps
module paged_xlate_unit
  import atu_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 10,
  parameter int HOST_AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xl_req,
  input  logic               xl_write,
  input  logic [ADDR_W-1:0]  xl_addr,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic               host_byte,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [ENT_W-1:0]   host_wdata,
  output logic [ENT_W-1:0]   host_rdata
);
  localparam int WIN_W = OFS_W + IDX_W;

  logic                 rst_ns;
  logic                 in_window;
  logic [IDX_W-1:0]     xl_idx;
  map_entry_t           xl_entry;
  logic [ADDR_W-1:0]    xl_xlated;
  logic                 upd_we;
  map_entry_t           upd_entry;
  logic [IDX_W-1:0]     host_idx;
  logic                 host_wr_en;
  logic [ENT_BYTES-1:0] host_be;
  map_entry_t           host_wr_data;
  map_entry_t           host_entry;
  logic                 host_hit;
  logic                 out_valid_d;
  logic [ADDR_W-1:0]    out_addr_d;
  logic                 out_valid_q;
  logic [ADDR_W-1:0]    out_addr_q;

  atu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign in_window = (xl_addr[ADDR_W-1:WIN_W] == '0);
  assign xl_idx    = xl_addr[WIN_W-1:OFS_W];
  assign xl_xlated = {{(ADDR_W-WIN_W){1'b0}}, xl_entry[IDX_W-1:0], xl_addr[OFS_W-1:0]};
  assign host_hit  = host_wr_en && (host_idx == xl_idx);

  atu_map_mem #(.IDX_W(IDX_W)) u_map (
    .clk     (clk),
    .a_idx   (xl_idx),
    .a_rdata (xl_entry),
    .a_we    (upd_we),
    .a_wdata (upd_entry),
    .b_idx   (host_idx),
    .b_rdata (host_entry),
    .b_we    (host_wr_en),
    .b_be    (host_be),
    .b_wdata (host_wr_data)
  );

  atu_status_upd u_upd (
    .xl_req    (xl_req),
    .xl_write  (xl_write),
    .in_window (in_window),
    .host_hit  (host_hit),
    .cur_entry (xl_entry),
    .upd_we    (upd_we),
    .upd_entry (upd_entry)
  );

  atu_host_port #(.IDX_W(IDX_W), .HOST_AW(HOST_AW)) u_host (
    .clk        (clk),
    .rst_n      (rst_ns),
    .host_req   (host_req),
    .host_wr    (host_wr),
    .host_byte  (host_byte),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .rd_entry   (host_entry),
    .idx        (host_idx),
    .wr_en      (host_wr_en),
    .wr_be      (host_be),
    .wr_data    (host_wr_data),
    .host_rdata (host_rdata)
  );

  always_comb begin
    out_valid_d = xl_req;
    out_addr_d  = in_window ? xl_xlated : xl_addr;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      out_valid_q <= 1'b0;
      out_addr_q  <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      if (xl_req) out_addr_q <= out_addr_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_addr  = out_addr_q;
endmodule

// File: rtl/atu_checker.sv
`timescale 1ns/1ps
module atu_checker
  import atu_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 10,
  parameter int HOST_AW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               xl_req,
  input logic               xl_write,
  input logic [ADDR_W-1:0]  xl_addr,
  input logic               out_valid,
  input logic [ADDR_W-1:0]  out_addr,
  input map_entry_t         xl_entry,
  input logic               upd_we,
  input map_entry_t         upd_entry,
  input logic               host_wr_en,
  input logic [HOST_AW-1:0] host_addr
);
  localparam int WIN_W = OFS_W + IDX_W;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> out_valid);  // R3
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> !out_valid);  // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> out_addr[OFS_W-1:0] == $past(xl_addr[OFS_W-1:0]));  // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && xl_addr[ADDR_W-1:WIN_W] != '0) |=> out_addr == $past(xl_addr));  // R1
  AST_UPD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> xl_addr[ADDR_W-1:WIN_W] == '0);  // R1
  AST_ABSENT_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> xl_entry[REF_BIT:MOD_BIT] != 2'b00);  // R4
  AST_REF_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> upd_entry[REF_BIT]);  // R5
  AST_MOD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && xl_write) |-> upd_entry[MOD_BIT]);  // R6
  AST_FIELDS_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> (upd_entry[WPROT_BIT] == xl_entry[WPROT_BIT]
                && upd_entry[MOD_BIT-1:0] == xl_entry[MOD_BIT-1:0]));  // R6
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_we |-> !(host_wr_en && host_addr[IDX_W:1] == xl_addr[WIN_W-1:OFS_W]));  // R10
endmodule

bind paged_xlate_unit atu_checker #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .HOST_AW(HOST_AW)
) u_atu_chk (
  .clk        (clk),
  .rst_n      (rst_ns),
  .xl_req     (xl_req),
  .xl_write   (xl_write),
  .xl_addr    (xl_addr),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .xl_entry   (xl_entry),
  .upd_we     (upd_we),
  .upd_entry  (upd_entry),
  .host_wr_en (host_wr_en),
  .host_addr  (host_addr)
);

// File: tb/paged_xlate_unit_bench.sv
`timescale 1ns/1ps
module paged_xlate_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        xl_req;
  logic        xl_write;
  logic [23:0] xl_addr;
  logic        out_valid;
  logic [23:0] out_addr;
  logic        host_req;
  logic        host_wr;
  logic        host_byte;
  logic [15:0] host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;

  int checks;
  int errors;
  logic [15:0] model [1024];

  paged_xlate_unit u_paged_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .xl_req(xl_req), .xl_write(xl_write), .xl_addr(xl_addr),
    .out_valid(out_valid), .out_addr(out_addr),
    .host_req(host_req), .host_wr(host_wr), .host_byte(host_byte),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [23:0] f_xlate(input logic [23:0] a, input logic [15:0] e);
    if (a >= 24'h400000) return a;
    return {2'b00, e[9:0], a[11:0]};
  endfunction

  function automatic logic [15:0] f_status(input logic [15:0] e, input logic wr);
    if (e[14:13] == 2'b00) return e;
    return wr ? (e | 16'h6000) : (e | 16'h4000);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at a falling edge, check at the next falling edge.
  task automatic step(input logic xr, input logic xw, input logic [23:0] xa,
                      input logic hr, input logic hw, input logic hb,
                      input logic [15:0] ha, input logic [15:0] hd, input string rtag);
    logic [23:0] exp_a;
    logic [15:0] exp_rd;
    int xi;
    int hi;
    xl_req = xr; xl_write = xw; xl_addr = xa;
    host_req = hr; host_wr = hw; host_byte = hb; host_addr = ha; host_wdata = hd;
    xi = int'(xa[21:12]);
    hi = int'(ha[10:1]);
    exp_a  = f_xlate(xa, model[xi]);
    exp_rd = hb ? {8'h00, (ha[0] ? model[hi][7:0] : model[hi][15:8])} : model[hi];
    if (xr && xa < 24'h400000 && !(hr && hw && hi == xi)) model[xi] = f_status(model[xi], xw);
    if (hr && hw) begin
      if (!hb)       model[hi] = hd;
      else if (ha[0]) model[hi][7:0]  = hd[7:0];
      else            model[hi][15:8] = hd[7:0];
    end
    @(negedge clk);
    if (xr) begin
      chk(out_valid === 1'b1, "R3 valid", {31'd0, out_valid}, 32'd1);
      chk(out_addr === exp_a, (xa >= 24'h400000) ? "R1 passthru" : "R2 xlate",
          {8'd0, out_addr}, {8'd0, exp_a});
    end else begin
      chk(out_valid === 1'b0, "R3 idle", {31'd0, out_valid}, 32'd0);
    end
    if (hr && !hw) chk(host_rdata === exp_rd, rtag, {16'd0, host_rdata}, {16'd0, exp_rd});
    xl_req = 1'b0; host_req = 1'b0;
  endtask

  task automatic host_write(input logic [15:0] ha, input logic [15:0] hd);
    step(1'b0, 1'b0, 24'd0, 1'b1, 1'b1, 1'b0, ha, hd, "");
  endtask

  task automatic host_read(input logic [15:0] ha, input logic hb, input string tag);
    step(1'b0, 1'b0, 24'd0, 1'b1, 1'b0, hb, ha, 16'd0, tag);
  endtask

  task automatic dump_all(input string tag);
    for (int i = 0; i < 1024; i++) begin
      logic [4:0] mir;
      mir = 5'($urandom);
      host_read({mir, 10'(i), 1'b0}, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    void'($urandom(32'h0A7C_5EED));
    rst_n = 1'b0;
    xl_req = 1'b0; xl_write = 1'b0; xl_addr = '0;
    host_req = 1'b0; host_wr = 1'b0; host_byte = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: reset state
    chk(out_valid === 1'b0, "R3 reset valid", {31'd0, out_valid}, 32'd0);
    chk(out_addr === 24'd0, "R3 reset addr", {8'd0, out_addr}, 32'd0);
    chk(host_rdata === 16'd0, "R3 reset rdata", {16'd0, host_rdata}, 32'd0);

    // load whole table with random contents (R7 word writes)
    for (int i = 0; i < 1024; i++) host_write({5'd0, 10'(i), 1'b0}, 16'($urandom));

    // R4: absent page keeps entry for read and write
    host_write(16'h000A, 16'h9ABC);
    step(1'b1, 1'b0, 24'h005123, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    step(1'b1, 1'b1, 24'h005FFE, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    host_read(16'h000A, 1'b0, "R4 absent kept");
    chk(model[5] === 16'h9ABC, "R4 model", {16'd0, model[5]}, 32'h9ABC);
    // R5: read sets referenced only
    host_write(16'h000E, 16'h2123);
    step(1'b1, 1'b0, 24'h007044, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    host_read(16'h000E, 1'b0, "R5 ref set");
    chk(model[7] === 16'h6123, "R5 model", {16'd0, model[7]}, 32'h6123);
    // R6: write sets both flags, keeps the protect bit
    host_write(16'h0010, 16'hA155);
    step(1'b1, 1'b1, 24'h008ABC, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    host_read(16'h0010, 1'b0, "R6 mod set");
    chk(model[8] === 16'hE155, "R6 model", {16'd0, model[8]}, 32'hE155);
    // R10: host word write wins on the same entry; translation uses old value
    host_write(16'h0012, 16'h4011);
    step(1'b1, 1'b1, 24'h009010, 1'b1, 1'b1, 1'b0, 16'h0012, 16'h0777, "");
    host_read(16'h0012, 1'b0, "R10 word wins");
    chk(model[9] === 16'h0777, "R10 model", {16'd0, model[9]}, 32'h0777);
    // R10: host byte write to the same entry also drops the status update
    host_write(16'h0012, 16'h2000);
    step(1'b1, 1'b0, 24'h009000, 1'b1, 1'b1, 1'b1, 16'h0013, 16'h0055, "");
    host_read(16'h0012, 1'b0, "R10 byte wins");
    chk(model[9] === 16'h2055, "R10 byte model", {16'd0, model[9]}, 32'h2055);
    // R8: byte lanes, big-endian
    host_write(16'h0014, 16'h1234);
    step(1'b0, 1'b0, 24'd0, 1'b1, 1'b1, 1'b1, 16'h0014, 16'hFFAB, "");
    host_read(16'h0014, 1'b0, "R8 even byte write");
    host_read(16'h0014, 1'b1, "R8 even byte read");
    host_read(16'h0015, 1'b1, "R8 odd byte read");
    // R9: mirrored host address
    host_write(16'hF816, 16'hBEEF);
    host_read(16'h0016, 1'b0, "R9 mirror");
    host_read(16'h7817, 1'b0, "R7 bit0 ignored");
    // R1/R2: window edges
    host_write(16'h07FE, 16'h4155);
    step(1'b1, 1'b0, 24'h3FFFFF, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    step(1'b1, 1'b1, 24'h400000, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    step(1'b1, 1'b1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    host_read(16'h07FE, 1'b0, "R1 no update");
    // back-to-back on one page: second sees first update
    step(1'b1, 1'b0, 24'h00A000, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    step(1'b1, 1'b1, 24'h00A004, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0, "");
    host_read(16'h0014, 1'b0, "R6 back to back");

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic xr, xw, hr, hw, hb;
      logic [23:0] xa;
      logic [15:0] ha;
      xr = ($urandom % 4) != 0;
      xw = 1'($urandom);
      xa = (($urandom % 6) == 0) ? 24'($urandom) : {2'b00, 22'($urandom)};
      hr = 1'($urandom);
      hw = 1'($urandom);
      hb = 1'($urandom);
      ha = 16'($urandom);
      if (($urandom % 3) == 0) ha[10:1] = xa[21:12];
      step(xr, xw, xa, hr, hw, hb, ha, 16'($urandom), hb ? "R8 rand read" : "R7 rand read");
    end
    dump_all("R5 table contents");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule